// File: doc/BRIEF.md
# Two-Phase Stepper Phase Sequencer

This block keeps the rotor position of a two-phase stepper motor as one of eight half-step states. It drives four active-low phase enables, one for each end of winding A and of winding B. Each falling edge on the step input moves the position by one command. The direction and step-size inputs are captured at that same edge. The block also reports, on two active-low status flags, when winding A or winding B is unpowered, so that a separate power stage can follow the position. An inhibit input releases every phase drive. Step edges are still counted while inhibit is high.

The step, direction and mode inputs arrive asynchronously. They pass together through one two-flop synchroniser, so direction and mode stay aligned with the step edge they belong to. A falling step edge is detected in the system clock domain. The power-good event is modelled as a synchronous, active-high reset, which parks the motor in a defined two-phase state. The block has no streaming data path, so every pin is a plain level with no valid/ready handshake and no back-pressure.

Top module: `step_phase_seq`

## Requirements
- R1: After reset, phase_n is 4'b1010 (bit order {B2,B1,A2,A1}, so A1 and B1 are driven) and both flags are 1.
- R2: The position changes only on a falling edge of step_in. A rising edge, or a level held for any number of cycles, leaves the outputs unchanged.
- R3: With half_n_in low, a step moves exactly one state through the ring A1, A1+B1, B1, B1+A2, A2, A2+B2, B2, B2+A1.
- R4: With half_n_in high and the position on a two-phase state, a step moves two states, from one two-phase state to the next.
- R5: With half_n_in high and the position on a one-phase state, a step moves one state, to the nearest two-phase state in the commanded direction.
- R6: dir_in high steps forward through the ring order of R3 and dir_in low steps backward. Both directions wrap around the ring.
- R7: dir_in and half_n_in act only at a falling step edge. A change between edges has no effect on the outputs until the next falling edge.
- R8: While inhibit_in is high, phase_n is 4'b1111 and the flags still report the position. Steps taken during inhibit still move the position.
- R9: flag_a_n is 0 exactly in the one-phase states B1 and B2 (winding A unpowered). flag_b_n is 0 exactly in A1 and A2 (winding B unpowered).
- R10: Outputs take their new value on the 4th rising clock edge after step_in falls, and not before. A change on inhibit_in shows on the 1st rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-good) |
| step_in | input | 1 | Step command, acts on its falling edge, idles high |
| dir_in | input | 1 | 1 = forward, 0 = reverse |
| half_n_in | input | 1 | 0 = half-step, 1 = full-step |
| inhibit_in | input | 1 | 1 releases all phase drives |
| phase_n | output | 4 | Active-low phase enables {B2,B1,A2,A1} |
| flag_a_n | output | 1 | 0 while winding A is unpowered |
| flag_b_n | output | 1 | 0 while winding B is unpowered |

## Verification
A falling step edge needs two synchroniser edges, one position-register edge and one output-register edge. Its result is therefore due on the fourth rising edge, and an inhibit change is due on the first. The bench drives every input on a falling clock edge and samples on a falling edge. After each step pulse it waits six cycles, well past the four-edge latency, before it compares. One directed test samples after exactly three edges and again after four, to pin the step latency to the cycle. Another samples one edge after an inhibit change.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;
  localparam int RING_LEN = 8;
  localparam int POS_W    = $clog2(RING_LEN);
  localparam int PHASES   = 4;

  typedef logic [POS_W-1:0] pos_t;

  // active-high winding-end drives, packed {B2,B1,A2,A1}
  typedef struct packed {
    logic b2;
    logic b1;
    logic a2;
    logic a1;
  } drive_t;

  // park state: A1+B1
  localparam pos_t HOME_POS = pos_t'(1);

  function automatic drive_t ring_drive(pos_t p);
    drive_t d;
    d.a1 = (p == pos_t'(7)) || (p <= pos_t'(1));
    d.b1 = (p >= pos_t'(1)) && (p <= pos_t'(3));
    d.a2 = (p >= pos_t'(3)) && (p <= pos_t'(5));
    d.b2 = (p >= pos_t'(5));
    return d;
  endfunction
endpackage

// File: rtl/step_sync.sv
module step_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,     // bit 0 is the edge-detected input
  output logic [WIDTH-2:0] ctl_q,   // remaining bits, aligned with the edge
  output logic             fall
);
  logic [WIDTH-1:0] stg [STAGES];
  logic             edge_prev;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[g] <= RST_VAL;
      else     stg[g] <= stg[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) edge_prev <= RST_VAL[0];
    else     edge_prev <= stg[STAGES-1][0];
  end

  assign fall  = edge_prev & ~stg[STAGES-1][0];
  assign ctl_q = stg[STAGES-1][WIDTH-1:1];

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/pos_ring.sv
module pos_ring
  import stepseq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic fwd,
  input  logic full,
  output pos_t pos
);
  pos_t stride;
  pos_t pos_nx;

  always_comb begin
    stride = (full && pos[0]) ? pos_t'(2) : pos_t'(1);
    pos_nx = fwd ? pos + stride : pos - stride;
  end

  always_ff @(posedge clk) begin
    if (rst)      pos <= HOME_POS;
    else if (adv) pos <= pos_nx;
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(pos));
  // R3
  step_moves_chk: assert property (@(posedge clk) disable iff (rst)
    adv |=> pos != $past(pos));
  // R5
  full_lands_two_phase_chk: assert property (@(posedge clk) disable iff (rst)
    adv && full |=> pos[0]);
endmodule

// File: rtl/phase_out.sv
module phase_out
  import stepseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  pos_t              pos,
  input  logic              inhibit,
  output logic [PHASES-1:0] phase_n,
  output logic              flag_a_n,
  output logic              flag_b_n
);
  drive_t drv;

  always_comb drv = ring_drive(pos);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_n  <= ~ring_drive(HOME_POS);
      flag_a_n <= 1'b1;
      flag_b_n <= 1'b1;
    end else begin
      phase_n  <= inhibit ? '1 : ~drv;
      flag_a_n <= drv.a1 | drv.a2;
      flag_b_n <= drv.b1 | drv.b2;
    end
  end

  // R8
  inhibit_release_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(inhibit) |-> phase_n == '1);
  // R3
  one_or_two_on_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(inhibit) |->
      ($countones(~phase_n) >= 1 && $countones(~phase_n) <= 2));
  // R9
  flag_a_consistent_chk: assert property (@(posedge clk) disable iff (rst)
    !flag_a_n |-> phase_n[1:0] == 2'b11);
  // R9
  flag_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(flag_a_n == 1'b0 && flag_b_n == 1'b0));
endmodule

// File: rtl/step_phase_seq.sv
module step_phase_seq
  import stepseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step_in,
  input  logic       dir_in,
  input  logic       half_n_in,
  input  logic       inhibit_in,
  output logic [3:0] phase_n,
  output logic       flag_a_n,
  output logic       flag_b_n
);
  localparam int SYNC_STAGES = 2;

  logic [1:0] ctl_q;   // {half_n, dir} captured with the step edge
  logic       step_fall;
  pos_t       pos;

  step_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b111)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({half_n_in, dir_in, step_in}),
    .ctl_q(ctl_q),
    .fall (step_fall)
  );

  pos_ring u_ring (
    .clk (clk),
    .rst (rst),
    .adv (step_fall),
    .fwd (ctl_q[0]),
    .full(ctl_q[1]),
    .pos (pos)
  );

  phase_out u_out (
    .clk     (clk),
    .rst     (rst),
    .pos     (pos),
    .inhibit (inhibit_in),
    .phase_n (phase_n),
    .flag_a_n(flag_a_n),
    .flag_b_n(flag_b_n)
  );

  // R1
  reset_home_chk: assert property (@(posedge clk)
    $past(rst) |-> phase_n == 4'b1010 && flag_a_n && flag_b_n);
endmodule

// File: tb/tb_step_phase_seq.sv
module tb_step_phase_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_in = 1'b1;
  logic       dir_in = 1'b1;
  logic       half_n_in = 1'b1;
  logic       inhibit_in = 1'b0;
  logic [3:0] phase_n;
  logic       flag_a_n, flag_b_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  step_phase_seq dut (
    .clk(clk), .rst(rst), .step_in(step_in), .dir_in(dir_in),
    .half_n_in(half_n_in), .inhibit_in(inhibit_in),
    .phase_n(phase_n), .flag_a_n(flag_a_n), .flag_b_n(flag_b_n)
  );

  // {dir, half_n, inhibit, phase_n[3:0], flag_a_n, flag_b_n}
  localparam logic [8:0] VEC [14] = '{
    9'b1_1_0_1001_1_1,  // fwd full 1->3        R4 R6
    9'b1_1_0_0101_1_1,  // fwd full 3->5        R4
    9'b1_0_0_0111_0_1,  // fwd half 5->6        R3 R9
    9'b1_1_0_0110_1_1,  // fwd full 6->7        R5
    9'b1_1_0_1010_1_1,  // fwd full 7->1 wrap   R4 R6
    9'b0_0_0_1110_1_0,  // rev half 1->0        R3 R6 R9
    9'b0_0_0_0110_1_1,  // rev half 0->7 wrap   R6
    9'b0_1_0_0101_1_1,  // rev full 7->5        R4
    9'b0_0_0_1101_1_0,  // rev half 5->4        R3 R9
    9'b0_1_0_1001_1_1,  // rev full 4->3        R5
    9'b1_0_1_1111_1_0,  // fwd half 3->4 inh    R8
    9'b1_0_0_0101_1_1,  // fwd half 4->5        R8
    9'b1_0_0_0111_0_1,  // fwd half 5->6        R3
    9'b0_1_0_0101_1_1   // rev full 6->5        R5
  };

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got phase_n/flags %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] obs();
    return {phase_n, flag_a_n, flag_b_n};
  endfunction

  task automatic pulse_step(input logic d, input logic h, input logic inh);
    @(negedge clk);
    dir_in = d; half_n_in = h; inhibit_in = inh;
    @(negedge clk);
    step_in = 1'b0;
    repeat (3) @(negedge clk);
    step_in = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset state", obs(), 6'b1010_11);

    for (int i = 0; i < 14; i++) begin
      pulse_step(VEC[i][8], VEC[i][7], VEC[i][6]);
      chk($sformatf("R3/R4/R5/R6/R8/R9 vector %0d", i), obs(), VEC[i][5:0]);
    end
    inhibit_in = 1'b0;
    // now at state 5 (A2+B2)

    // R2: long low level, then rise and long high level
    @(negedge clk);
    dir_in = 1'b1; half_n_in = 1'b0;
    @(negedge clk);
    step_in = 1'b0;
    repeat (20) @(negedge clk);
    chk("R2 single advance on long low", obs(), 6'b0111_01);
    step_in = 1'b1;
    repeat (20) @(negedge clk);
    chk("R2 rising edge ignored", obs(), 6'b0111_01);

    // R7: change dir/mode one cycle after the falling edge
    step_in = 1'b0;
    @(negedge clk);
    dir_in = 1'b0; half_n_in = 1'b1;
    repeat (8) @(negedge clk);
    chk("R7 late dir/mode ignored", obs(), 6'b0110_11);
    step_in = 1'b1;
    repeat (10) @(negedge clk);
    chk("R7 no effect between edges", obs(), 6'b0110_11);
    step_in = 1'b0;
    repeat (3) @(negedge clk);
    step_in = 1'b1;
    repeat (6) @(negedge clk);
    chk("R7 new values at next edge", obs(), 6'b0101_11);

    // R10 / R8: inhibit latency and release
    inhibit_in = 1'b1;
    @(negedge clk);
    chk("R10 inhibit after one edge", obs(), 6'b1111_11);
    inhibit_in = 1'b0;
    @(negedge clk);
    chk("R8 release restores drive", obs(), 6'b0101_11);

    // R10: step latency, fwd half 5->6
    dir_in = 1'b1; half_n_in = 1'b0;
    @(negedge clk);
    step_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 not before 4th edge", obs(), 6'b0101_11);
    @(negedge clk);
    chk("R10 on 4th edge", obs(), 6'b0111_01);
    step_in = 1'b1;
    repeat (6) @(negedge clk);

    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run", obs(), 6'b1010_11);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule